// File: doc/BRIEF.md
# Byte Bus Decoder with Paired 16-bit Transfers

This block sits behind a byte-wide processor request port and steers every access by its 16-bit address. The low half of the address space goes to an external synchronous program ROM, an 8 KB window goes to an external synchronous work RAM, and a 128-byte high RAM near the top of the space is held inside the block. Any other address is treated as unmapped. A read there yields the byte 0x00. A write there is refused and flagged with a one-cycle error pulse.

A second request port carries 16-bit transfers. The block performs each one as two byte accesses in a fixed order. A read fetches the byte at the address and then the byte at the address plus one, and returns them little-endian. A write stores the upper byte at the address plus one first, then the lower byte at the address. If that first store is refused, the second is dropped. The address plus one wraps within 16 bits. The processor sees busy for two cycles and then a one-cycle done strobe.

Single-byte requests are served in one cycle, and read data appears the following cycle. Both external stores are expected to have a one-cycle read latency.

Top module: `membus_decoder`

## Requirements
- R1: A byte read below 0x8000 drives the ROM port with the low 15 address bits, and the ROM's byte is returned on `rsp_rdata` with `rsp_valid` high in the cycle after the request.
- R2: Addresses 0xC000 to 0xDFFF reach the work RAM port at offset address minus 0xC000; a byte written there reads back unchanged, and an unwritten byte returns whatever the RAM supplies at that offset.
- R3: Addresses 0xFF80 to 0xFFFE reach the internal high RAM at offset address minus 0xFF80; each of its 127 reachable bytes reads back the last value written.
- R4: A byte read from an unmapped address returns 0x00 with `rsp_valid` high. Unmapped means 0x8000–0xBFFF, 0xE000–0xFF7F, and 0xFFFF.
- R5: A byte write to an unmapped address raises `wr_error` for exactly the cycle after the request and changes no store.
- R6: A byte write below 0x8000 is accepted silently: `wr_error` stays low and no work RAM strobe is issued.
- R7: A 16-bit read returns {byte at addr+1, byte at addr}, where each byte follows R1–R4 and addr+1 wraps from 0xFFFF to 0x0000.
- R8: A 16-bit write stores bits 15:8 at addr+1 in its first byte cycle and bits 7:0 at addr in its second.
- R9: If the first byte of a 16-bit write hits an unmapped address, the second byte is not issued, and the transfer raises `wr_error` exactly once. If only the second byte is unmapped, the first byte is stored and `wr_error` pulses once.
- R10: After the edge that accepts `wide_start`, `wide_busy` is high for two cycles, then `wide_done` is high for one cycle with `wide_busy` low, and then both are low.
- R11: A byte request is ignored while a 16-bit transfer is in progress and in the cycle that presents `wide_start`.
- R12: Out of reset, `wide_busy`, `wide_done`, `rsp_valid` and `wr_error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Byte request present |
| req_write | input | 1 | Byte request is a write |
| req_addr | input | 16 | Byte request address |
| req_wdata | input | 8 | Byte write data |
| rsp_valid | output | 1 | Byte read data valid |
| rsp_rdata | output | 8 | Byte read data |
| wr_error | output | 1 | Pulse: a write hit an unmapped address |
| wide_start | input | 1 | Start a 16-bit transfer (taken when idle) |
| wide_write | input | 1 | 16-bit transfer is a write |
| wide_addr | input | 16 | 16-bit transfer base address |
| wide_wdata | input | 16 | 16-bit write data |
| wide_busy | output | 1 | 16-bit transfer in its byte cycles |
| wide_done | output | 1 | 16-bit transfer complete |
| wide_rdata | output | 16 | Assembled read data, valid with `wide_done` |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 15 | ROM byte address |
| rom_data | input | 8 | ROM data, one cycle after `rom_rd` |
| wram_en | output | 1 | Work RAM access strobe |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | 13 | Work RAM byte offset |
| wram_wdata | output | 8 | Work RAM write data |
| wram_rdata | input | 8 | Work RAM data, one cycle after a read strobe |

## Verification
A byte request is applied before one rising edge. Its read data, `rsp_valid` and `wr_error` are all due in the cycle after that edge, so the bench drives on a falling edge and samples on the next falling edge. For a 16-bit transfer, the bench samples at the three falling edges after the accepting edge. It expects busy at the first two and done at the third. `wide_rdata` is read at the third, and `wr_error` is summed over all three, because each byte's error surfaces one cycle after its access. Store ordering and the absence of strobes are checked by a monitor that logs the work RAM port on every edge.

// File: rtl/membus_decoder.sv
module membus_decoder #(
  parameter logic [7:0] OPEN_BUS = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic        wr_error,
  input  logic        wide_start,
  input  logic        wide_write,
  input  logic [15:0] wide_addr,
  input  logic [15:0] wide_wdata,
  output logic        wide_busy,
  output logic        wide_done,
  output logic [15:0] wide_rdata,
  output logic        rom_rd,
  output logic [14:0] rom_addr,
  input  logic [7:0]  rom_data,
  output logic        wram_en,
  output logic        wram_we,
  output logic [12:0] wram_addr,
  output logic [7:0]  wram_wdata,
  input  logic [7:0]  wram_rdata
);

  localparam int HRAM_DEPTH = 128;
  localparam logic [1:0] SRC_NONE = 2'd0, SRC_ROM = 2'd1, SRC_WRAM = 2'd2, SRC_HRAM = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_DONE} state_t;

  state_t      st;
  logic [15:0] w_addr, w_data;
  logic        w_wr;
  logic [15:0] w_addr_inc;
  logic        in_second;

  logic        acc_en, acc_we;
  logic [15:0] acc_addr;
  logic [7:0]  acc_wd;
  logic        hit_rom, hit_wram, hit_hram;
  logic [1:0]  src, src_q;
  logic [7:0]  hram [HRAM_DEPTH];
  logic [7:0]  hram_q, lo_q, rd_byte;

  assign w_addr_inc = w_addr + 16'd1;
  assign in_second  = (st == ST_SECOND);

  always_comb begin
    acc_en   = 1'b0;
    acc_we   = req_write;
    acc_addr = req_addr;
    acc_wd   = req_wdata;
    case (st)
      ST_IDLE:   acc_en = req_valid && !wide_start;
      ST_FIRST: begin
        acc_en   = 1'b1;
        acc_we   = w_wr;
        acc_addr = w_wr ? w_addr_inc : w_addr;
        acc_wd   = w_data[15:8];
      end
      ST_SECOND: begin
        acc_en   = !(w_wr && wr_error);
        acc_we   = w_wr;
        acc_addr = w_wr ? w_addr : w_addr_inc;
        acc_wd   = w_data[7:0];
      end
      default: ;
    endcase
  end

  assign hit_rom  = !acc_addr[15];
  assign hit_wram = (acc_addr[15:13] == 3'b110);
  assign hit_hram = (&acc_addr[15:7]) && !(&acc_addr[6:0]);
  assign src      = hit_rom ? SRC_ROM : hit_wram ? SRC_WRAM : hit_hram ? SRC_HRAM : SRC_NONE;

  assign rom_rd     = acc_en && !acc_we && hit_rom;
  assign rom_addr   = acc_addr[14:0];
  assign wram_en    = acc_en && hit_wram;
  assign wram_we    = acc_we;
  assign wram_addr  = acc_addr[12:0];
  assign wram_wdata = acc_wd;

  always_ff @(posedge clk) begin
    if (acc_en && hit_hram) begin
      if (acc_we) hram[acc_addr[6:0]] <= acc_wd;
      else        hram_q <= hram[acc_addr[6:0]];
    end
  end

  always_comb begin
    case (src_q)
      SRC_ROM:  rd_byte = rom_data;
      SRC_WRAM: rd_byte = wram_rdata;
      SRC_HRAM: rd_byte = hram_q;
      default:  rd_byte = OPEN_BUS;
    endcase
  end

  assign rsp_rdata  = rd_byte;
  assign wide_rdata = {rd_byte, lo_q};
  assign wide_busy  = (st == ST_FIRST) || (st == ST_SECOND);
  assign wide_done  = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rsp_valid <= 1'b0;
      wr_error  <= 1'b0;
      src_q     <= SRC_NONE;
    end else begin
      rsp_valid <= acc_en && !acc_we && (st == ST_IDLE);
      wr_error  <= acc_en && acc_we && (src == SRC_NONE);
      src_q     <= (acc_en && !acc_we) ? src : SRC_NONE;
      case (st)
        ST_IDLE:   if (wide_start) st <= ST_FIRST;
        ST_FIRST:  st <= ST_SECOND;
        ST_SECOND: st <= ST_DONE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == ST_IDLE && wide_start) begin
      w_addr <= wide_addr;
      w_data <= wide_wdata;
      w_wr   <= wide_write;
    end
    if (in_second) lo_q <= rd_byte;
  end

endmodule

// File: rtl/membus_decoder_chk.sv
module membus_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wide_busy,
  input logic        wide_done,
  input logic        wr_error,
  input logic        acc_en,
  input logic        acc_we,
  input logic [15:0] acc_addr,
  input logic        in_second,
  input logic        w_wr,
  input logic        wram_en,
  input logic        rom_rd
);

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wide_busy) |=> wide_busy);

  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_busy && $past(wide_busy)) |=> (wide_done && !wide_busy));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wide_done |=> (!wide_done && !wide_busy));

  a_r6_rom_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && !acc_addr[15]) |=> !wr_error);

  a_r5_unmapped_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && acc_addr[15:13] == 3'b111 && acc_addr[15:7] != 9'h1FF) |=> wr_error);

  a_r9_abort_second: assert property (@(posedge clk) disable iff (!rst_n)
    (in_second && w_wr && wr_error) |-> (!wram_en && !rom_rd));

endmodule

bind membus_decoder membus_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wide_busy(wide_busy), .wide_done(wide_done),
  .wr_error(wr_error), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
  .in_second(in_second), .w_wr(w_wr), .wram_en(wram_en), .rom_rd(rom_rd)
);

// File: tb/membus_decoder_bench.sv
module membus_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic rsp_valid, wr_error;
  logic [7:0] rsp_rdata;
  logic wide_start = 0, wide_write = 0;
  logic [15:0] wide_addr = 0, wide_wdata = 0;
  logic wide_busy, wide_done;
  logic [15:0] wide_rdata;
  logic rom_rd;
  logic [14:0] rom_addr;
  logic [7:0] rom_data = 0;
  logic wram_en, wram_we;
  logic [12:0] wram_addr;
  logic [7:0] wram_wdata, wram_rdata = 0;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  membus_decoder u_membus_decoder (.*);

  function automatic logic [7:0] rom_f(logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] wdef(logic [12:0] a);
    return 8'hC3 ^ a[7:0] ^ {3'b0, a[12:8]};
  endfunction

  logic [7:0] wmem [int];
  int wr_strobes = 0;
  logic [12:0] last_w = 0, prev_w = 0;

  always @(posedge clk) begin
    if (rom_rd) rom_data <= rom_f(rom_addr);
    if (wram_en) begin
      if (wram_we) begin
        wmem[int'(wram_addr)] = wram_wdata;
        wr_strobes++;
        prev_w = last_w;
        last_w = wram_addr;
      end else
        wram_rdata <= wmem.exists(int'(wram_addr)) ? wmem[int'(wram_addr)] : wdef(wram_addr);
    end
  end

  logic [7:0] exp_w [int];
  logic [7:0] exp_h [128];

  function automatic logic [7:0] exp_rd(logic [15:0] a);
    if (!a[15]) return rom_f(a[14:0]);
    if (a >= 16'hC000 && a <= 16'hDFFF) begin
      int o = int'(a - 16'hC000);
      return exp_w.exists(o) ? exp_w[o] : wdef(o[12:0]);
    end
    if (a >= 16'hFF80 && a <= 16'hFFFE) return exp_h[a[6:0]];
    return 8'h00;
  endfunction

  task automatic exp_wr(input logic [15:0] a, input logic [7:0] d, output bit err);
    err = 0;
    if (a >= 16'hC000 && a <= 16'hDFFF) exp_w[int'(a - 16'hC000)] = d;
    else if (a >= 16'hFF80 && a <= 16'hFFFE) exp_h[a[6:0]] = d;
    else if (a[15]) err = 1;
  endtask

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic byte_op(input bit we, input logic [15:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output bit rv, output bit er);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd = rsp_rdata; rv = rsp_valid; er = wr_error;
  endtask

  task automatic rd_check(input string req, input logic [15:0] a);
    logic [7:0] rd; bit rv, er;
    byte_op(0, a, 8'h00, rd, rv, er);
    check(req, rv && rd == exp_rd(a) && !er, $sformatf("read @%04h", a),
          {rv, er, 8'h0, rd}, {1'b1, 1'b0, 8'h0, exp_rd(a)});
  endtask

  task automatic wr_check(input string req, input logic [15:0] a, input logic [7:0] d);
    logic [7:0] rd; bit rv, er, e;
    exp_wr(a, d, e);
    byte_op(1, a, d, rd, rv, er);
    check(req, er == e && !rv, $sformatf("write err @%04h", a), {rv, er}, {1'b0, e});
  endtask

  task automatic wide_op(input string req, input bit we, input logic [15:0] a,
                         input logic [15:0] d, input bit inject);
    int errs = 0;
    logic [15:0] got = 0;
    bit timing_ok = 1;
    logic [15:0] exp = {exp_rd(a + 16'd1), exp_rd(a)};
    int exp_err = 0;
    bit e;
    if (we) begin
      exp_wr(a + 16'd1, d[15:8], e);
      exp_err = int'(e);
      if (!e) begin exp_wr(a, d[7:0], e); exp_err += int'(e); end
    end
    @(negedge clk);
    wide_start = 1; wide_write = we; wide_addr = a; wide_wdata = d;
    if (inject) begin
      req_valid = 1; req_write = 1; req_addr = 16'hFF85; req_wdata = 8'hEE;
    end
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      wide_start = 0;
      errs += int'(wr_error);
      if (k < 3 && !(wide_busy && !wide_done)) timing_ok = 0;
      if (k == 3) begin
        if (!(wide_done && !wide_busy)) timing_ok = 0;
        got = wide_rdata;
        req_valid = 0; req_write = 0;
      end
    end
    check("R10", timing_ok, $sformatf("busy/done timing @%04h", a), {wide_busy, wide_done}, 2'b01);
    if (we) check("R9", errs == exp_err, $sformatf("wide write errors @%04h", a), errs, exp_err);
    else    check("R7", got == exp, $sformatf("wide read @%04h", a), got, exp);
    @(negedge clk);
    check("R10", !wide_busy && !wide_done, "idle after done", {wide_busy, wide_done}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int strobes_before;
    repeat (3) @(negedge clk);
    check("R12", !wide_busy && !wide_done && !rsp_valid && !wr_error, "reset outputs",
          {wide_busy, wide_done, rsp_valid, wr_error}, 0);
    rst_n = 1;

    // R3: fill and read back the whole high RAM
    for (int i = 0; i < 127; i++) wr_check("R3", 16'hFF80 + 16'(i), 8'(i * 37 + 11));
    for (int i = 0; i < 127; i++) rd_check("R3", 16'hFF80 + 16'(i));

    // R1: ROM sweep
    for (int a = 0; a < 16'h8000; a += 16'h0101) rd_check("R1", 16'(a));
    rd_check("R1", 16'h7FFF);

    // R2: unwritten reads expose the offset, then write/read
    for (int a = 16'hC000; a <= 16'hDFFF; a += 16'h0123) rd_check("R2", 16'(a));
    for (int a = 16'hC000; a <= 16'hDFFF; a += 16'h0211) wr_check("R2", 16'(a), 8'(a >> 3));
    wr_check("R2", 16'hDFFF, 8'h77);
    for (int a = 16'hC000; a <= 16'hDFFF; a += 16'h0211) rd_check("R2", 16'(a));
    rd_check("R2", 16'hDFFF);

    // R4: unmapped reads
    for (int a = 16'h8000; a < 16'hC000; a += 16'h0401) rd_check("R4", 16'(a));
    for (int a = 16'hE000; a < 16'hFF80; a += 16'h0203) rd_check("R4", 16'(a));
    rd_check("R4", 16'hFF7F);
    rd_check("R4", 16'hFFFF);

    // R5: unmapped writes flag and change nothing
    strobes_before = wr_strobes;
    wr_check("R5", 16'hE000, 8'h99);
    wr_check("R5", 16'hFFFF, 8'h99);
    wr_check("R5", 16'h9000, 8'h99);
    wr_check("R5", 16'hFF7F, 8'h99);
    check("R5", wr_strobes == strobes_before, "no RAM strobe on unmapped write", wr_strobes, strobes_before);
    rd_check("R5", 16'hC000);
    rd_check("R5", 16'hFFFE);
    rd_check("R5", 16'hFF80);

    // R6: ROM writes silent
    strobes_before = wr_strobes;
    wr_check("R6", 16'h0000, 8'h12);
    wr_check("R6", 16'h7FFF, 8'h34);
    check("R6", wr_strobes == strobes_before, "no RAM strobe on ROM write", wr_strobes, strobes_before);
    rd_check("R6", 16'h7FFF);

    // R7: wide reads
    wide_op("R7", 0, 16'h0100, 0, 0);
    wide_op("R7", 0, 16'hC010, 0, 0);
    wide_op("R7", 0, 16'hFF90, 0, 0);
    wide_op("R7", 0, 16'h7FFF, 0, 0);
    wide_op("R7", 0, 16'hFFFE, 0, 0);
    wide_op("R7", 0, 16'hFFFF, 0, 0);

    // R8: wide write order
    wide_op("R8", 1, 16'hC100, 16'hBEEF, 0);
    check("R8", prev_w == 13'h101 && last_w == 13'h100, "store order", {prev_w, 3'b0, last_w}, {13'h101, 3'b0, 13'h100});
    rd_check("R8", 16'hC100);
    rd_check("R8", 16'hC101);
    wide_op("R8", 1, 16'hFFA0, 16'h1234, 0);
    wide_op("R8", 0, 16'hFFA0, 0, 0);

    // R9: aborts and second-byte failure
    strobes_before = wr_strobes;
    wide_op("R9", 1, 16'hDFFF, 16'hAA55, 0);
    check("R9", wr_strobes == strobes_before, "aborted second byte not stored", wr_strobes, strobes_before);
    rd_check("R9", 16'hDFFF);
    wide_op("R9", 1, 16'hFFFE, 16'hCC33, 0);
    rd_check("R9", 16'hFFFE);
    wide_op("R9", 1, 16'hBFFF, 16'h5AA5, 0);
    rd_check("R9", 16'hC000);
    wide_op("R9", 1, 16'hFFFF, 16'h6116, 0);

    // R11: byte request during a wide transfer is ignored
    wide_op("R11", 0, 16'hC200, 0, 1);
    rd_check("R11", 16'hFF85);
    wide_op("R11", 1, 16'hC300, 16'h0F0F, 1);
    rd_check("R11", 16'hFF85);
    rd_check("R11", 16'hC300);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule